// File: doc/BRIEF.md
# Dual-Lane Pixel Exchanger with Overlay and Border Blanking

This block sits on a video path that moves pixels two at a time: one lane holds the odd-numbered pixel of a pair and the other holds the even-numbered one, so each lane runs at half the dot rate. At its front it decides, per line, which physical lane carries which pixel. The choice flips on every new line and on every new frame. Any fixed gain or offset difference between the two lanes therefore lands on odd columns in one line and on even columns in the next, and the pattern moves again from frame to frame.

The exchanged lanes leave the block, pass through external lane processing with a fixed latency `PROC_LAT`, and come back in. A restore stage uses the same swap decision, delayed to match, to put the pixels back in odd/even order. A final stage tracks the output position. It forces a programmable black code inside programmable top, bottom, left and right borders, and it replaces the video with an on-screen-display colour wherever the display enable is high. The default geometry is 1024 by 768 pixels, which gives 512 pairs per line.

Top module: `pixel_lane_exchanger`

## Requirements
- R1: After reset, `xch_valid` and `out_valid` are 0, and both the line parity and the frame parity are 0.
- R2: A pulse on `in_vs` toggles the frame parity and clears the line parity. A pulse on `in_hs` toggles the line parity. For each valid pair, swap = line parity XOR frame parity. With swap 0, lane A carries the odd pixel and lane B the even pixel; with swap 1 the lanes are exchanged. `xch_*` is registered one clock after the input.
- R3: With no border and no display enable, `out_odd` and `out_even` hold the odd and even pixel of the input pair, each carrying whatever the external processing did on the lane that pixel travelled through. With identical lanes, the output equals the input.
- R4: A pair inside any border is output as `black_code` on both pixels. Blanking has priority over the display overlay.
- R5: Outside the borders, when `osd_en` (aligned with `ret_valid`) is 1, both output pixels take the value of `osd_color`.
- R6: Lines are counted from 0 at the first `in_hs` after `in_vs`, and pairs from 0 at each `in_hs`. A pair is in a border when line < `blk_top`, line >= LINES-`blk_bottom`, pair < `blk_left` or pair >= PAIRS-`blk_right`. Pairs before the first line of a frame are blanked.
- R7: `out_valid` rises exactly PROC_LAT+3 clocks after a valid input pair. Every input pair produces exactly one output pair, in order. Sync pulses fall on cycles with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair valid |
| in_hs | input | 1 | Line start pulse |
| in_vs | input | 1 | Frame start pulse |
| in_odd | input | DW | Odd pixel of the pair |
| in_even | input | DW | Even pixel of the pair |
| xch_valid | output | 1 | Exchanged pair valid |
| xch_a | output | DW | Physical lane A after exchange |
| xch_b | output | DW | Physical lane B after exchange |
| ret_valid | input | 1 | Processed pair valid |
| ret_a | input | DW | Processed lane A |
| ret_b | input | DW | Processed lane B |
| osd_en | input | 1 | Display overlay enable, aligned with ret_valid |
| osd_color | input | DW | Display overlay colour |
| blk_top | input | LW | Blanked lines at top |
| blk_bottom | input | LW | Blanked lines at bottom |
| blk_left | input | CW | Blanked pairs at left |
| blk_right | input | CW | Blanked pairs at right |
| black_code | input | DW | Code forced in borders |
| out_valid | output | 1 | Output pair valid |
| out_odd | output | DW | Restored odd pixel |
| out_even | output | DW | Restored even pixel |

## Verification
Suppose the parity state or the delayed swap bit is off by one line. Then every pair of the affected line comes out with odd and even exchanged, and the bench sees this on the first output pair of that line. It also sees it on the lane ports one clock after the input. Because the two lanes are given different offsets, a restore that uses a misaligned swap bit shows up as the wrong offset on an output pixel. A wrong position counter shows up as blanking or overlay on the wrong pair, within the first line where a border edge is crossed.

// File: rtl/plx_pkg.sv
package plx_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic swap;
  } plx_ctl_t;
endpackage

// File: rtl/lane_exchange.sv
module lane_exchange
  import plx_pkg::*;
#(
  parameter int DW  = 10,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic [DW-1:0] in_odd,
  input  logic [DW-1:0] in_even,
  output logic          x_valid,
  output logic [DW-1:0] x_a,
  output logic [DW-1:0] x_b,
  output plx_ctl_t      d_ctl
);
  logic     line_par_q, line_par_d;
  logic     frame_par_q, frame_par_d;
  logic     swap_cur;
  logic     pair_en;
  plx_ctl_t x_ctl;
  plx_ctl_t dly [LAT];

  assign swap_cur = line_par_q ^ frame_par_q;
  assign pair_en  = in_valid;

  always_comb begin
    line_par_d  = line_par_q;
    frame_par_d = frame_par_q;
    if (in_vs) begin
      frame_par_d = ~frame_par_q;
      line_par_d  = 1'b0;
    end else if (in_hs) begin
      line_par_d = ~line_par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_par_q  <= 1'b0;
      frame_par_q <= 1'b0;
      x_valid     <= 1'b0;
      x_ctl       <= '0;
    end else begin
      line_par_q  <= line_par_d;
      frame_par_q <= frame_par_d;
      x_valid     <= in_valid;
      x_ctl       <= '{hs: in_hs, vs: in_vs, swap: swap_cur};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_a <= '0;
      x_b <= '0;
    end else if (pair_en) begin
      x_a <= swap_cur ? in_even : in_odd;
      x_b <= swap_cur ? in_odd  : in_even;
    end
  end

  for (genvar g = 0; g < LAT; g++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly[g] <= '0;
      else if (g == 0) dly[g] <= x_ctl;
      else             dly[g] <= dly[(g == 0) ? 0 : g-1];
    end
  end

  assign d_ctl = dly[LAT-1];

  assert_xchg_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> x_valid);

  assert_lane_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((x_a == $past(in_odd)  && x_b == $past(in_even)) ||
                  (x_a == $past(in_even) && x_b == $past(in_odd))));
endmodule

// File: rtl/lane_restore.sv
module lane_restore
  import plx_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic [DW-1:0] ret_a,
  input  logic [DW-1:0] ret_b,
  input  plx_ctl_t      d_ctl,
  input  logic          osd_en,
  input  logic [DW-1:0] osd_color,
  output logic          r_valid,
  output logic          r_hs,
  output logic          r_vs,
  output logic [DW-1:0] r_odd,
  output logic [DW-1:0] r_even,
  output logic          r_osd,
  output logic [DW-1:0] r_osd_color
);
  logic [DW-1:0] odd_d, even_d;

  always_comb begin
    odd_d  = d_ctl.swap ? ret_b : ret_a;
    even_d = d_ctl.swap ? ret_a : ret_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_hs    <= 1'b0;
      r_vs    <= 1'b0;
    end else begin
      r_valid <= ret_valid;
      r_hs    <= d_ctl.hs;
      r_vs    <= d_ctl.vs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_odd       <= '0;
      r_even      <= '0;
      r_osd       <= 1'b0;
      r_osd_color <= '0;
    end else if (ret_valid) begin
      r_odd       <= odd_d;
      r_even      <= even_d;
      r_osd       <= osd_en;
      r_osd_color <= osd_color;
    end
  end

  assert_restore_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ((r_odd == $past(ret_a) && r_even == $past(ret_b)) ||
                   (r_odd == $past(ret_b) && r_even == $past(ret_a))));
endmodule

// File: rtl/pixel_overlay.sv
module pixel_overlay #(
  parameter int DW    = 10,
  parameter int PAIRS = 512,
  parameter int LINES = 768,
  localparam int LW   = $clog2(LINES + 1),
  localparam int CW   = $clog2(PAIRS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          r_valid,
  input  logic          r_hs,
  input  logic          r_vs,
  input  logic [DW-1:0] r_odd,
  input  logic [DW-1:0] r_even,
  input  logic          r_osd,
  input  logic [DW-1:0] r_osd_color,
  input  logic [LW-1:0] blk_top,
  input  logic [LW-1:0] blk_bottom,
  input  logic [CW-1:0] blk_left,
  input  logic [CW-1:0] blk_right,
  input  logic [DW-1:0] black_code,
  output logic          out_valid,
  output logic [DW-1:0] out_odd,
  output logic [DW-1:0] out_even
);
  localparam logic [LW:0] LINES_X = (LW+1)'(LINES);
  localparam logic [CW:0] PAIRS_X = (CW+1)'(PAIRS);

  logic [LW-1:0] line_q, line_d;
  logic [CW-1:0] col_q, col_d;
  logic          in_border;
  logic [DW-1:0] odd_d, even_d;

  always_comb begin
    line_d = line_q;
    col_d  = col_q;
    if (r_vs) begin
      line_d = '1;
      col_d  = '0;
    end else if (r_hs) begin
      line_d = line_q + 1'b1;
      col_d  = '0;
    end else if (r_valid) begin
      col_d = col_q + 1'b1;
    end
  end

  always_comb begin
    in_border = (line_q < blk_top) ||
                (({1'b0, line_q} + {1'b0, blk_bottom}) >= LINES_X) ||
                (col_q < blk_left) ||
                (({1'b0, col_q} + {1'b0, blk_right}) >= PAIRS_X);
    if (in_border) begin
      odd_d  = black_code;
      even_d = black_code;
    end else if (r_osd) begin
      odd_d  = r_osd_color;
      even_d = r_osd_color;
    end else begin
      odd_d  = r_odd;
      even_d = r_even;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '1;
      col_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      line_q    <= line_d;
      col_q     <= col_d;
      out_valid <= r_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_odd  <= '0;
      out_even <= '0;
    end else if (r_valid) begin
      out_odd  <= odd_d;
      out_even <= even_d;
    end
  end

  assert_out_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |=> out_valid);

  assert_out_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !r_valid |=> !out_valid);
endmodule

// File: rtl/pixel_lane_exchanger.sv
module pixel_lane_exchanger
  import plx_pkg::*;
#(
  parameter int DW       = 10,
  parameter int PAIRS    = 512,
  parameter int LINES    = 768,
  parameter int PROC_LAT = 3,
  localparam int LW      = $clog2(LINES + 1),
  localparam int CW      = $clog2(PAIRS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic [DW-1:0] in_odd,
  input  logic [DW-1:0] in_even,
  output logic          xch_valid,
  output logic [DW-1:0] xch_a,
  output logic [DW-1:0] xch_b,
  input  logic          ret_valid,
  input  logic [DW-1:0] ret_a,
  input  logic [DW-1:0] ret_b,
  input  logic          osd_en,
  input  logic [DW-1:0] osd_color,
  input  logic [LW-1:0] blk_top,
  input  logic [LW-1:0] blk_bottom,
  input  logic [CW-1:0] blk_left,
  input  logic [CW-1:0] blk_right,
  input  logic [DW-1:0] black_code,
  output logic          out_valid,
  output logic [DW-1:0] out_odd,
  output logic [DW-1:0] out_even
);
  plx_ctl_t      d_ctl;
  logic          r_valid, r_hs, r_vs, r_osd;
  logic [DW-1:0] r_odd, r_even, r_osd_color;

  lane_exchange #(.DW(DW), .LAT(PROC_LAT)) u_xchg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_hs(in_hs), .in_vs(in_vs),
    .in_odd(in_odd), .in_even(in_even),
    .x_valid(xch_valid), .x_a(xch_a), .x_b(xch_b),
    .d_ctl(d_ctl)
  );

  lane_restore #(.DW(DW)) u_rest (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_a(ret_a), .ret_b(ret_b),
    .d_ctl(d_ctl), .osd_en(osd_en), .osd_color(osd_color),
    .r_valid(r_valid), .r_hs(r_hs), .r_vs(r_vs),
    .r_odd(r_odd), .r_even(r_even),
    .r_osd(r_osd), .r_osd_color(r_osd_color)
  );

  pixel_overlay #(.DW(DW), .PAIRS(PAIRS), .LINES(LINES)) u_ovl (
    .clk(clk), .rst_n(rst_n),
    .r_valid(r_valid), .r_hs(r_hs), .r_vs(r_vs),
    .r_odd(r_odd), .r_even(r_even),
    .r_osd(r_osd), .r_osd_color(r_osd_color),
    .blk_top(blk_top), .blk_bottom(blk_bottom),
    .blk_left(blk_left), .blk_right(blk_right),
    .black_code(black_code),
    .out_valid(out_valid), .out_odd(out_odd), .out_even(out_even)
  );
endmodule

// File: tb/pixel_lane_exchanger_bench.sv
module pixel_lane_exchanger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int PAIRS = 8;
  localparam int LINES = 6;
  localparam int LAT = 3;
  localparam int LW = $clog2(LINES + 1);
  localparam int CW = $clog2(PAIRS + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_hs, in_vs;
  logic [DW-1:0] in_odd, in_even;
  logic xch_valid;
  logic [DW-1:0] xch_a, xch_b;
  logic ret_valid, osd_en;
  logic [DW-1:0] ret_a, ret_b, osd_color;
  logic [LW-1:0] blk_top, blk_bottom;
  logic [CW-1:0] blk_left, blk_right;
  logic [DW-1:0] black_code;
  logic out_valid;
  logic [DW-1:0] out_odd, out_even;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_lane_exchanger #(.DW(DW), .PAIRS(PAIRS), .LINES(LINES), .PROC_LAT(LAT))
  u_pixel_lane_exchanger (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hs(in_hs), .in_vs(in_vs),
    .in_odd(in_odd), .in_even(in_even), .xch_valid(xch_valid), .xch_a(xch_a),
    .xch_b(xch_b), .ret_valid(ret_valid), .ret_a(ret_a), .ret_b(ret_b),
    .osd_en(osd_en), .osd_color(osd_color), .blk_top(blk_top),
    .blk_bottom(blk_bottom), .blk_left(blk_left), .blk_right(blk_right),
    .black_code(black_code), .out_valid(out_valid), .out_odd(out_odd),
    .out_even(out_even)
  );

  // external lane processing model: fixed latency, per-lane offset
  logic [DW-1:0] off_a, off_b;
  logic          osd_drv;
  logic [DW-1:0] osd_col_drv;
  logic [DW-1:0] pa [LAT];
  logic [DW-1:0] pb [LAT];
  logic          pv [LAT];
  logic          po [LAT+1];
  logic [DW-1:0] pc [LAT+1];

  always @(posedge clk) begin
    pa[0] <= xch_a + off_a;
    pb[0] <= xch_b + off_b;
    pv[0] <= rst_n ? xch_valid : 1'b0;
    po[0] <= osd_drv;
    pc[0] <= osd_col_drv;
    for (int i = 1; i < LAT; i++) begin
      pa[i] <= pa[i-1]; pb[i] <= pb[i-1]; pv[i] <= pv[i-1];
    end
    for (int i = 1; i <= LAT; i++) begin
      po[i] <= po[i-1]; pc[i] <= pc[i-1];
    end
  end
  assign ret_a = pa[LAT-1];
  assign ret_b = pb[LAT-1];
  assign ret_valid = pv[LAT-1];
  assign osd_en = po[LAT];
  assign osd_color = pc[LAT];

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] q_odd[$], q_even[$];
  string q_tag[$];
  int b_line, b_col;
  bit b_lp, b_fp;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output checker: in-order comparison against the bench's own prediction
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_odd.size() == 0) begin
        check(1'b0, "R7 extra output", 1, 0);
      end else begin
        logic [DW-1:0] eo, ee;
        string t;
        eo = q_odd.pop_front(); ee = q_even.pop_front(); t = q_tag.pop_front();
        check(out_odd == eo, t, out_odd, eo);
        check(out_even == ee, t, out_even, ee);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_hs = 1'b0; in_vs = 1'b0; osd_drv = 1'b0;
    end
  endtask

  task automatic pulse_vs();
    @(negedge clk); in_valid = 1'b0; in_vs = 1'b1;
    b_fp = ~b_fp; b_lp = 1'b0; b_line = -1; b_col = 0;
    @(negedge clk); in_vs = 1'b0;
  endtask

  task automatic pulse_hs();
    @(negedge clk); in_valid = 1'b0; in_hs = 1'b1;
    b_lp = ~b_lp; b_line++; b_col = 0;
    @(negedge clk); in_hs = 1'b0;
  endtask

  function automatic bit in_border(input int ln, input int cl);
    return (ln < int'(blk_top)) || (ln >= LINES - int'(blk_bottom)) ||
           (cl < int'(blk_left)) || (cl >= PAIRS - int'(blk_right));
  endfunction

  // drives one pair at a negedge, predicts it, checks the lane ports (R2)
  task automatic drive_pair(input logic [DW-1:0] o, input logic [DW-1:0] e,
                            input bit osd, input logic [DW-1:0] oc, input bit lane_chk);
    bit sw;
    logic [DW-1:0] xo, xe;
    sw = b_lp ^ b_fp;
    in_valid = 1'b1; in_odd = o; in_even = e; osd_drv = osd; osd_col_drv = oc;
    xo = o + (sw ? off_b : off_a);
    xe = e + (sw ? off_a : off_b);
    if (in_border(b_line, b_col)) begin
      q_odd.push_back(black_code); q_even.push_back(black_code); q_tag.push_back("R4 R6 border");
    end else if (osd) begin
      q_odd.push_back(oc); q_even.push_back(oc); q_tag.push_back("R5 overlay");
    end else begin
      q_odd.push_back(xo); q_even.push_back(xe); q_tag.push_back("R3 restore");
    end
    b_col++;
    @(negedge clk);
    in_valid = 1'b0; osd_drv = 1'b0;
    if (lane_chk) begin
      check(xch_valid == 1'b1, "R2 lane valid", xch_valid, 1);
      check(xch_a == (sw ? e : o), "R2 lane A", xch_a, sw ? e : o);
      check(xch_b == (sw ? o : e), "R2 lane B", xch_b, sw ? o : e);
    end
  endtask

  task automatic drain(input string req);
    idle(LAT + 6);
    check(q_odd.size() == 0, req, q_odd.size(), 0);
  endtask

  task automatic run_frame(input int oa, input int ob, input bit osd_on, input int seed);
    off_a = DW'(oa); off_b = DW'(ob);
    pulse_vs();
    for (int l = 0; l < LINES; l++) begin
      pulse_hs();
      for (int c = 0; c < PAIRS; c++) begin
        drive_pair(DW'(seed + l*37 + c*11), DW'(seed*3 + l*5 + c*29 + 1),
                   osd_on && ((l + c) % 3 == 0), DW'(200 + c), 1'b1);
      end
      idle(2);
    end
    drain("R7 all pairs delivered");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 0; in_hs = 0; in_vs = 0; in_odd = 0; in_even = 0;
    osd_drv = 0; osd_col_drv = 0; off_a = 0; off_b = 0;
    blk_top = 0; blk_bottom = 0; blk_left = 0; blk_right = 0; black_code = 8'h10;
    b_lp = 0; b_fp = 0; b_line = -1; b_col = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(LAT + 2);
    check(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);
    check(xch_valid == 1'b0, "R1 xch_valid reset", xch_valid, 0);
  endtask

  task automatic t_identity();    // R3 with identical lanes, two frames
    run_frame(0, 0, 1'b0, 7);
    run_frame(0, 0, 1'b0, 19);
  endtask

  task automatic t_mismatch();    // R3 and R2 across line and frame parity
    run_frame(5, 200, 1'b0, 3);
    run_frame(5, 200, 1'b0, 41);
    run_frame(250, 9, 1'b0, 77);
  endtask

  task automatic t_borders();     // R4 R5 R6
    blk_top = 2; blk_bottom = 1; blk_left = 3; blk_right = 2; black_code = 8'h2A;
    run_frame(13, 60, 1'b1, 11);
    blk_top = 0; blk_bottom = 0; blk_left = 0; blk_right = 0;
    run_frame(1, 2, 1'b1, 90);
  endtask

  task automatic t_latency();     // R7
    int n;
    off_a = 0; off_b = 0;
    pulse_vs(); pulse_hs();
    drive_pair(8'h55, 8'hAA, 1'b0, 8'h00, 1'b0);
    n = 1;
    while (!out_valid && n < 30) begin
      @(negedge clk); n++;
    end
    check(n == LAT + 3, "R7 latency", n, LAT + 3);
    drain("R7 single pair delivered");
  endtask

  initial begin
    t_reset();
    t_identity();
    t_mismatch();
    t_borders();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule